// File: doc/BRIEF.md
# Cascaded Scan Pacer with Interrupt Latch

The block paces an acquisition sequencer. Two down-counters are chained: the first one divides a timebase strobe (a one-cycle enable that marks each tick of the 10 MHz reference), and the second one divides the terminal events of the first. Each terminal event of the second stage can fire a one-cycle scan-start pulse toward the converter sequencer. A clock/interrupt register enables pacing and chooses between the counter chain and an external clock input. Software sets up each stage with a control word and then writes its count byte by byte. With a first-stage count of 200 the chain produces 50 kHz events, and the second stage then gives the scan period.

When the sequencer reports that a scan is done, the block latches a pending interrupt, provided the interrupt enable is set. The flag stays up until software writes a one to the clear bit of the control register. That register also holds a two-bit page field. The counter registers answer only when the page field is 0.

Top module: `scan_pacer`

## Requirements
- R1: Control word 0x56 written at offset 15 selects stage one (bits 7:6 = 01) with low-byte-only access (bits 5:4 = 01). One write of the count at offset 13 starts it. Stage one advances only in cycles with `tb_tick` high, so with the timebase strobe high every cycle the scan-start pulses come every N1*N2 cycles.
- R2: Control word 0xB6 (bits 7:6 = 10, bits 5:4 = 11) selects stage two with two-byte access. The count is written at offset 14, low byte first then high byte. Stage two is clocked by the terminal events of stage one.
- R3: A programmed count of 0 acts as 2^W, which is 256 for the 8-bit first stage.
- R4: A count written while a stage runs takes effect at that stage's next reload. A lone low byte in two-byte access changes nothing.
- R5: Writes to offsets 13, 14 and 15 are ignored unless the page field (offset 8, bits 1:0) is 0.
- R6: Offset 9 bit 0 selects the source: 1 is the stage-two terminal event and 0 is a rising edge of `ext_clk`. Each event while pacing is enabled gives exactly one `scan_start` pulse, one cycle later. A held-high `ext_clk` gives no further pulses.
- R7: Offset 9 bit 1 is the pacing enable. While it is 0, and after a write of 0x00, no scan-start pulse is issued.
- R8: `scan_done` with the interrupt enable (offset 9 bit 7) set raises `irq` on the next cycle. The flag then stays set, and further scan-done events merge into it.
- R9: Writing offset 8 with bit 3 set clears `irq` on the next cycle. A scan-done in the same cycle wins, and the flag stays set.
- R10: Reading offset 9 returns the pending flag in bit 7, the pacing enable in bit 1 and the source select in bit 0, with all other bits 0. Reading offset 8 returns the page in bits 1:0. Both read 0 after reset.
- R11: Control word 0x96 gives stage two low-byte-only access. A control word is ignored if its mode field (bits 3:1) is not 011 or 111, if its BCD bit (bit 0) is set, or if its access field is 00.
- R12: A valid control word stops its stage until a complete count is written. The stage then restarts on a later tick with the new count.
- R13: `scan_done` has no effect on `irq` while the interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Timebase strobe; stage one advances in cycles where it is high |
| ext_clk | input | 1 | External scan clock, synchronous to clk |
| scan_done | input | 1 | One-cycle end-of-scan event from the sequencer |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset for writes and reads |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| scan_start | output | 1 | One-cycle scan-start pulse |
| irq | output | 1 | Pending end-of-scan interrupt |

## Verification
The bench uses the default widths: 8 bits for stage one and 16 bits for stage two. The 8-bit first stage lets the zero-count wrap to 256 show up in a few hundred cycles. Small second-stage counts keep each measured period to tens of cycles, so reload timing, stop-and-restart and page gating are each checked over several periods. A strobe that is high on alternate cycles doubles the period, which confirms that the counters follow the timebase strobe and not the system clock.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam logic [3:0] A_CTRL   = 4'd8;
  localparam logic [3:0] A_INTCLK = 4'd9;
  localparam logic [3:0] A_CNT1   = 4'd13;
  localparam logic [3:0] A_CNT2   = 4'd14;
  localparam logic [3:0] A_CWORD  = 4'd15;

  localparam int B_CLR   = 3;
  localparam int B_INTEN = 7;
  localparam int B_CLKEN = 1;
  localparam int B_SRC   = 0;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } cword_t;

  // Only binary square-wave words with a real access mode are accepted.
  function automatic logic cword_ok(input cword_t c);
    return (c.acc != ACC_LATCH) && !c.bcd &&
           ((c.mode == 3'b011) || (c.mode == 3'b111));
  endfunction
endpackage

// File: rtl/sp_stage.sv
module sp_stage
  import sp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  acc_e       ctl_acc,
  input  logic       cnt_wr,
  input  logic [7:0] wdata,
  input  logic       tick,
  output logic       term
);
  localparam int CW = W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  // Effective period: a zero count stands for 2^W.
  function automatic logic [CW-1:0] to_count(input logic [7:0] lo, input logic [7:0] hi);
    logic [W-1:0] raw;
    raw = W'({hi, lo});
    if (raw == '0) return {1'b1, {W{1'b0}}};
    return {1'b0, raw};
  endfunction

  acc_e          acc_q;
  logic          hi_next;
  logic [7:0]    lo_q;
  logic [CW-1:0] cnt_q;
  logic          loaded;
  logic          running;
  logic [CW-1:0] val;

  logic          complete;
  logic [CW-1:0] new_cnt;

  always_comb begin
    complete = 1'b0;
    new_cnt  = '0;
    unique case (acc_q)
      ACC_LO:   begin complete = 1'b1;    new_cnt = to_count(wdata, 8'h00); end
      ACC_HI:   begin complete = 1'b1;    new_cnt = to_count(8'h00, wdata); end
      ACC_BOTH: begin complete = hi_next; new_cnt = to_count(lo_q, wdata);  end
      default:  begin complete = 1'b0;    new_cnt = '0;                     end
    endcase
  end

  assign term = tick && running && (val == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= ACC_LATCH;
      hi_next <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
      loaded  <= 1'b0;
      running <= 1'b0;
      val     <= '0;
    end else if (ctl_wr) begin
      acc_q   <= ctl_acc;
      hi_next <= 1'b0;
      loaded  <= 1'b0;
      running <= 1'b0;
    end else begin
      if (cnt_wr) begin
        if (acc_q == ACC_BOTH && !hi_next) begin
          lo_q    <= wdata;
          hi_next <= 1'b1;
        end else if (complete) begin
          hi_next <= 1'b0;
          cnt_q   <= new_cnt;
          loaded  <= 1'b1;
        end
      end
      if (tick) begin
        if (running) begin
          if (val == ONE) val <= cnt_q;
          else            val <= val - ONE;
        end else if (loaded) begin
          running <= 1'b1;
          val     <= cnt_q;
        end
      end
    end
  end

  // R4: a terminal event reloads the latched count
  a_r4_reload_on_term: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !ctl_wr) |=> (val == $past(cnt_q)));
  // R12: a control word silences the stage
  a_r12_stop_on_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !term);
endmodule

// File: rtl/sp_irq.sv
module sp_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (clr_evt) pend <= 1'b0;
  end

  // R8: set and hold
  a_r8_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_evt) |=> pend);
  // R9: clear unless a new event arrives
  a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !pend);
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer
  import sp_pkg::*;
#(
  parameter int P1_W = 8,
  parameter int P2_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_tick,
  input  logic       ext_clk,
  input  logic       scan_done,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       scan_start,
  output logic       irq
);
  logic [1:0] page_q;
  logic       int_en_q, clk_en_q, src_q, ext_q, scan_q;

  logic ctr_open, wr_ctrl, clr_evt, set_evt;
  logic cw_valid, ctl1, ctl2, cnt1, cnt2;
  logic term1, term2, ext_rise, src_evt, pend;
  acc_e cw_acc;

  assign ctr_open = (page_q == 2'd0);
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign clr_evt  = wr_ctrl && wdata[B_CLR];
  assign set_evt  = scan_done && int_en_q;

  assign cw_valid = wr_en && ctr_open && (addr == A_CWORD) && cword_ok(cword_t'(wdata));
  assign cw_acc   = acc_e'(wdata[5:4]);
  assign ctl1     = cw_valid && (wdata[7:6] == 2'b01);
  assign ctl2     = cw_valid && (wdata[7:6] == 2'b10);
  assign cnt1     = wr_en && ctr_open && (addr == A_CNT1);
  assign cnt2     = wr_en && ctr_open && (addr == A_CNT2);

  sp_stage #(.W(P1_W)) u_div1 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl1), .ctl_acc(cw_acc),
    .cnt_wr(cnt1), .wdata(wdata), .tick(tb_tick), .term(term1)
  );

  sp_stage #(.W(P2_W)) u_div2 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl2), .ctl_acc(cw_acc),
    .cnt_wr(cnt2), .wdata(wdata), .tick(term1), .term(term2)
  );

  sp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt), .pend(pend)
  );

  assign ext_rise = ext_clk && !ext_q;
  assign src_evt  = src_q ? term2 : ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      int_en_q <= 1'b0;
      clk_en_q <= 1'b0;
      src_q    <= 1'b0;
      ext_q    <= 1'b0;
      scan_q   <= 1'b0;
    end else begin
      ext_q  <= ext_clk;
      scan_q <= clk_en_q && src_evt;
      if (wr_ctrl) page_q <= wdata[1:0];
      if (wr_en && addr == A_INTCLK) begin
        int_en_q <= wdata[B_INTEN];
        clk_en_q <= wdata[B_CLKEN];
        src_q    <= wdata[B_SRC];
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:   rdata = {6'b0, page_q};
      A_INTCLK: rdata = {pend, 5'b0, clk_en_q, src_q};
      default:  rdata = 8'h00;
    endcase
  end

  assign scan_start = scan_q;
  assign irq        = pend;

  // R7: pacing disabled means no pulse
  a_r7_no_scan_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_q |=> !scan_start);
  // R6: a held external clock gives no second pulse
  a_r6_ext_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_q && ext_q && ext_clk) |=> !scan_start);
  // R6: a counter terminal event with pacing on fires one pulse
  a_r6_counter_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q && clk_en_q && term2) |=> scan_start);
endmodule

// File: tb/tb_scan_pacer.sv
`timescale 1ns/1ps
module tb_scan_pacer;
  logic clk = 1'b0, rst_n = 1'b0, tb_tick = 1'b1, ext_clk = 1'b0, scan_done = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        scan_start, irq;

  scan_pacer dut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .ext_clk(ext_clk), .scan_done(scan_done),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .scan_start(scan_start), .irq(irq)
  );

  always #10 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit half = 1'b0, done = 1'b0;
  always @(posedge clk) cyc++;
  always @(negedge clk) tb_tick <= half ? ~tb_tick : 1'b1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural interrupt reference (R8, R9, R13), compared every cycle.
  bit m_irq = 1'b0, m_ie = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_irq = 1'b0; m_ie = 1'b0;
    end else begin
      bit nxt;
      nxt = m_irq;
      if (scan_done && m_ie) nxt = 1'b1;
      else if (wr_en && addr == 4'd8 && wdata[3]) nxt = 1'b0;
      if (wr_en && addr == 4'd9) m_ie = wdata[7];
      m_irq = nxt;
    end
  end
  always @(negedge clk) if (rst_n && !done) chk("R8/R9 irq reference", irq, m_irq);

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(string tag, input logic [3:0] a, input int exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic next_pulse(output int t);
    t = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (scan_start) begin t = cyc; return; end
    end
  endtask

  task automatic quiet(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (scan_start) cnt++;
    end
  endtask

  task automatic expect_gap(string tag, input int exp, input int reps);
    int a, b;
    next_pulse(a);
    next_pulse(a);
    for (int i = 0; i < reps; i++) begin
      next_pulse(b);
      chk(tag, b - a, exp);
      a = b;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    int p0, p1, p2, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset scan_start", scan_start, 0);
    chk("R8 reset irq", irq, 0);
    rd("R10 reset offset 9", 4'd9, 0);
    rd("R10 reset offset 8", 4'd8, 0);

    // R1 R2: stage one = 4, stage two = 3 -> 12 cycles
    wr(4'd15, 8'h56); wr(4'd13, 8'd4);
    wr(4'd15, 8'hB6); wr(4'd14, 8'd3); wr(4'd14, 8'd0);
    wr(4'd9, 8'h03);
    rd("R10 readback enables", 4'd9, 8'h03);
    expect_gap("R1 R2 period 4x3", 12, 3);
    @(negedge clk);
    chk("R6 single-cycle pulse", scan_start, 0);

    // R1: timebase strobe at half rate doubles the period
    half = 1'b1;
    expect_gap("R1 half-rate timebase", 24, 2);
    half = 1'b0;
    expect_gap("R1 full-rate again", 12, 1);

    // R4: new count used from the next reload
    next_pulse(p0);
    wr(4'd14, 8'd5); wr(4'd14, 8'd0);
    next_pulse(p1); next_pulse(p2);
    chk("R4 old count until reload", p1 - p0, 12);
    chk("R4 new count after reload", p2 - p1, 20);

    // R5: counter writes off page 0 are ignored
    wr(4'd8, 8'h01);
    rd("R10 page readback", 4'd8, 1);
    wr(4'd15, 8'hB6); wr(4'd14, 8'd9); wr(4'd14, 8'd0);
    wr(4'd8, 8'h00);
    expect_gap("R5 page gating", 20, 2);

    // R12: control word stops the stage until a count arrives
    wr(4'd15, 8'hB6);
    quiet(200, n);
    chk("R12 stopped after control word", n, 0);
    wr(4'd14, 8'd2); wr(4'd14, 8'd0);
    expect_gap("R12 restart with new count", 8, 2);

    // R11: low-only access and rejected control words
    wr(4'd15, 8'h96); wr(4'd14, 8'd3);
    expect_gap("R11 low-byte-only count", 12, 2);
    wr(4'd15, 8'hB0);
    expect_gap("R11 bad mode ignored", 12, 1);
    wr(4'd15, 8'hB7);
    expect_gap("R11 BCD word ignored", 12, 1);
    wr(4'd15, 8'h86);
    expect_gap("R11 latch-access word ignored", 12, 1);

    // R3: zero count on stage one means 256
    wr(4'd15, 8'h56); wr(4'd13, 8'd0);
    wr(4'd15, 8'h96); wr(4'd14, 8'd2);
    expect_gap("R3 zero count wraps", 512, 1);

    // R7: pacing disabled
    wr(4'd9, 8'h01);
    repeat (2) @(negedge clk);
    quiet(600, n);
    chk("R7 no pulses with enable low", n, 0);
    wr(4'd9, 8'h00);
    rd("R7 R10 offset 9 after zero write", 4'd9, 0);
    quiet(600, n);
    chk("R7 no pulses after zero write", n, 0);

    // R6: external source
    wr(4'd9, 8'h02);
    repeat (2) @(negedge clk);
    quiet(600, n);
    chk("R6 counter ignored with source 0", n, 0);
    ext_clk = 1'b1;
    @(negedge clk);
    chk("R6 pulse on external rise", scan_start, 1);
    @(negedge clk);
    chk("R6 no pulse while held", scan_start, 0);
    quiet(5, n);
    chk("R6 held level quiet", n, 0);
    ext_clk = 1'b0;
    quiet(3, n);
    chk("R6 falling edge quiet", n, 0);
    ext_clk = 1'b1;
    @(negedge clk);
    chk("R6 second rise", scan_start, 1);
    ext_clk = 1'b0;

    // R8 R9 R10: interrupt latch
    wr(4'd9, 8'h80);
    scan_done = 1'b1; @(negedge clk); scan_done = 1'b0;
    chk("R8 irq set", irq, 1);
    rd("R10 pending in bit 7", 4'd9, 8'h80);
    repeat (10) @(negedge clk);
    chk("R8 irq held", irq, 1);
    scan_done = 1'b1; @(negedge clk); scan_done = 1'b0;
    chk("R8 merged event", irq, 1);
    wr(4'd8, 8'h08);
    chk("R9 cleared", irq, 0);
    rd("R10 page after clear write", 4'd8, 0);
    wr_en = 1'b1; addr = 4'd8; wdata = 8'h08; scan_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; scan_done = 1'b0;
    chk("R9 set wins over clear", irq, 1);
    wr(4'd8, 8'h08);
    chk("R9 cleared again", irq, 0);

    // R13: event ignored with enable low
    wr(4'd9, 8'h00);
    scan_done = 1'b1; @(negedge clk); scan_done = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13 no irq when disabled", irq, 0);
    rd("R13 offset 9 stays zero", 4'd9, 0);

    done = 1'b1;
    finish_run();
  end
endmodule